// File: doc/BRIEF.md
# Dual-Register Serial-to-Parallel Converter

This block takes a bit stream on one input and gathers it in a shift stage that is eight bits wide by default. A second stage of the same width drives the parallel outputs. The shift stage advances on the rising edge of its own clock. The storage stage takes a full copy of the shift stage on the rising edge of a second, independent clock. The parallel outputs therefore stay steady while new data is shifted in behind them, and they change all at once when the storage clock fires.

Each stage has its own active-low asynchronous clear. The last shift bit also appears on a cascade output, so that several converters can be chained into one longer register. The outputs are always driven. When both clocks come from the same net, the storage stage ends up holding the shift contents from one pulse earlier.

Top module: `sipo_store_top`

## Requirements
- R1: While `shiftClrN` is low, the shift stage is zero and `cascadeOut` is 0. While `storeClrN` is low, `parOut` is zero. Both clears act at once, without any clock edge.
- R2: On each rising edge of `shiftClk`, `serIn` enters bit 0 and each bit n moves to bit n+1. The old top bit is discarded.
- R3: `cascadeOut` always shows the top bit of the shift stage. That bit stays visible until the next `shiftClk` rising edge replaces it.
- R4: On a rising edge of `storeClk`, every shift bit is copied in parallel to `parOut`, with bit n going to `parOut[n]` and no inversion. Between such edges `parOut` does not change, even while shifting continues.
- R5: Asserting `shiftClrN` leaves `parOut` unchanged. Asserting `storeClrN` leaves the shift stage unchanged, which can be seen on `cascadeOut` and after the next store.
- R6: A clear that is held low overrides its stage's clock: rising edges during the clear leave that stage at zero.
- R7: With `shiftClk` and `storeClk` tied to one signal, `parOut` after each pulse equals the shift contents as they were before that pulse.
- R8: When a second converter takes `cascadeOut` of the first as its `serIn`, 16 shifts followed by one store leave the first 8 bits shifted in on the second converter's `parOut` and the last 8 bits on the first converter's `parOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| serIn | input | 1 | Serial data input, sampled on the rising edge of `shiftClk` |
| shiftClk | input | 1 | Clock for the shift stage, rising edge |
| storeClk | input | 1 | Clock for the storage stage, rising edge |
| shiftClrN | input | 1 | Asynchronous clear of the shift stage, active low |
| storeClrN | input | 1 | Asynchronous clear of the storage stage, active low |
| parOut | output | WIDTH | Parallel outputs, taken from the storage stage |
| cascadeOut | output | 1 | Top bit of the shift stage, for chaining |

## Verification
A shift and a store can fall in the same cycle when the two clocks are tied together. The bench provokes this by driving both clock edges from one statement for 16 pulses through a chain of two converters. After every pulse it compares `parOut` with a reference model's shift contents from before that pulse. The bench also provokes a clear of one stage while the other stage holds data, and judges at the ports that only the cleared stage went to zero.

// File: rtl/sipo_store_pkg.sv
package sipo_store_pkg;

  // Active-high clear strobes handed from control to datapath
  typedef struct packed {
    logic shiftClear;
    logic storeClear;
  } stageCtl_t;

endpackage

// File: rtl/sipo_store_ctrl.sv
module sipo_store_ctrl
  import sipo_store_pkg::*;
(
  input  logic      shiftClrN,
  input  logic      storeClrN,
  output stageCtl_t ctl
);

  // Convert the active-low pins into active-high strobes for each stage
  always_comb begin
    ctl.shiftClear = ~shiftClrN;
    ctl.storeClear = ~storeClrN;
  end

endmodule

// File: rtl/sipo_store_dp.sv
module sipo_store_dp
  import sipo_store_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             shiftClk,
  input  logic             storeClk,
  input  logic             serIn,
  input  stageCtl_t        ctl,
  output logic [WIDTH-1:0] shiftBits,
  output logic [WIDTH-1:0] storeBits
);

  localparam int TopBit = WIDTH - 1;

  logic             shClr;
  logic             stClr;
  logic [WIDTH-1:0] shiftNext;

  assign shClr = ctl.shiftClear;
  assign stClr = ctl.storeClear;

  // Next-state wiring for each shift cell
  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    if (g == 0) begin : g_head
      assign shiftNext[g] = serIn;
    end else begin : g_link
      assign shiftNext[g] = shiftBits[g-1];
    end
  end

  always_ff @(posedge shiftClk or posedge shClr) begin
    if (shClr) shiftBits <= '0;
    else       shiftBits <= shiftNext;
  end

  always_ff @(posedge storeClk or posedge stClr) begin
    if (stClr) storeBits <= '0;
    else       storeBits <= shiftBits;
  end

  // Checker shadow state: what each stage should hold after its last edge
  logic             shSeen;
  logic             stSeen;
  logic [WIDTH-1:0] shExp;
  logic [WIDTH-1:0] stExp;

  always_ff @(posedge shiftClk or posedge shClr) begin
    if (shClr) begin
      shSeen <= 1'b0;
      shExp  <= '0;
    end else begin
      shSeen <= 1'b1;
      shExp  <= {shiftBits[TopBit-1:0], serIn};
    end
  end

  always_ff @(posedge storeClk or posedge stClr) begin
    if (stClr) begin
      stSeen <= 1'b0;
      stExp  <= '0;
    end else begin
      stSeen <= 1'b1;
      stExp  <= shiftBits;
    end
  end

  // R2
  shift_step_chk: assert property (@(posedge shiftClk) disable iff (shClr)
    shSeen |-> shiftBits == shExp);

  // R4
  store_copy_chk: assert property (@(posedge storeClk) disable iff (stClr)
    stSeen |-> storeBits == stExp);

  // R6
  shift_clear_chk: assert property (@(posedge shiftClk)
    shClr |-> shiftBits == '0);

  // R6
  store_clear_chk: assert property (@(posedge storeClk)
    stClr |-> storeBits == '0);

endmodule

// File: rtl/sipo_store_top.sv
module sipo_store_top
  import sipo_store_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             serIn,
  input  logic             shiftClk,
  input  logic             storeClk,
  input  logic             shiftClrN,
  input  logic             storeClrN,
  output logic [WIDTH-1:0] parOut,
  output logic             cascadeOut
);

  stageCtl_t        ctl;
  logic [WIDTH-1:0] shiftBits;
  logic [WIDTH-1:0] storeBits;

  sipo_store_ctrl i_ctrl (
    .shiftClrN (shiftClrN),
    .storeClrN (storeClrN),
    .ctl       (ctl)
  );

  sipo_store_dp #(.WIDTH(WIDTH)) i_dp (
    .shiftClk  (shiftClk),
    .storeClk  (storeClk),
    .serIn     (serIn),
    .ctl       (ctl),
    .shiftBits (shiftBits),
    .storeBits (storeBits)
  );

  assign parOut     = storeBits;
  assign cascadeOut = shiftBits[WIDTH-1];

endmodule

// File: tb/test_sipo_store_top.sv
module test_sipo_store_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic       serIn = 1'b0;
  logic       shMan = 1'b0;
  logic       stMan = 1'b0;
  logic       tieMode = 1'b0;
  logic       shiftClrN = 1'b0;
  logic       storeClrN = 1'b0;
  logic       shiftClk;
  logic       storeClk;
  logic [7:0] parA;
  logic [7:0] parB;
  logic       casA;
  logic       casB;

  assign shiftClk = shMan;
  assign storeClk = tieMode ? shMan : stMan;

  sipo_store_top i_sipo_store_top (
    .serIn(serIn), .shiftClk(shiftClk), .storeClk(storeClk),
    .shiftClrN(shiftClrN), .storeClrN(storeClrN),
    .parOut(parA), .cascadeOut(casA)
  );

  sipo_store_top i_sipo_store_top_b (
    .serIn(casA), .shiftClk(shiftClk), .storeClk(storeClk),
    .shiftClrN(shiftClrN), .storeClrN(storeClrN),
    .parOut(parB), .cascadeOut(casB)
  );

  int         nRun = 0;
  int         nFail = 0;
  int         cyc = 0;
  logic [15:0] refBits = '0;   // model of the chained shift stages
  logic [15:0] prevBits = '0;
  logic [15:0] expPar = '0;    // model of the chained storage stages

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkPar(input string tag);
    check(tag, {parB, parA}, expPar);
  endtask

  task automatic checkCas(input string tag);
    check(tag, {14'd0, casB, casA}, {14'd0, refBits[15], refBits[7]});
  endtask

  task automatic doShift(input logic d);
    serIn = d;
    #2;
    shMan = 1'b1;
    prevBits = refBits;
    if (shiftClrN) refBits = {refBits[14:0], d};
    if (tieMode && storeClrN) expPar = prevBits;
    #4;
    shMan = 1'b0;
    #2;
  endtask

  task automatic doStore();
    #2;
    stMan = 1'b1;
    if (storeClrN) expPar = refBits;
    #4;
    stMan = 1'b0;
    #2;
  endtask

  function automatic logic patBit(input int i, input int seed);
    return ((i * seed + 3) % 7) > 2;
  endfunction

  task automatic testReset();
    #3;
    check("R1 reset parOut", {parB, parA}, 16'h0000);
    check("R1 reset cascade", {14'd0, casB, casA}, 16'h0000);
    shiftClrN = 1'b1;
    storeClrN = 1'b1;
    #5;
  endtask

  task automatic testShiftStore();
    for (int i = 0; i < 8; i++) begin
      doShift(patBit(i, 5));
      checkCas("R3 cascade follows top bit");
    end
    check("R4 parOut held before store", {parB, parA}, 16'h0000);
    doStore();
    checkPar("R2 R4 store after eight shifts");
    check("R2 first byte", {8'd0, parA}, {8'd0, refBits[7:0]});
  endtask

  task automatic testHold();
    logic [15:0] held;
    held = {parB, parA};
    for (int i = 0; i < 3; i++) begin
      doShift(~patBit(i, 3));
      check("R4 parOut steady while shifting", {parB, parA}, held);
      checkCas("R3 cascade while holding");
    end
    doStore();
    checkPar("R4 store after extra shifts");
  endtask

  task automatic testIndependence();
    logic [15:0] held;
    held = {parB, parA};
    shiftClrN = 1'b0;
    refBits = '0;
    #3;
    check("R1 shift clear zeroes cascade", {14'd0, casB, casA}, 16'h0000);
    check("R5 shift clear keeps parOut", {parB, parA}, held);
    shiftClrN = 1'b1;
    #3;
    doStore();
    checkPar("R1 store after shift clear gives zero");
    for (int i = 0; i < 10; i++) doShift(patBit(i, 11));
    doStore();
    checkPar("R4 store before store clear");
    storeClrN = 1'b0;
    expPar = '0;
    #3;
    checkPar("R1 store clear zeroes parOut");
    checkCas("R5 store clear keeps shift stage");
    storeClrN = 1'b1;
    #3;
    doStore();
    checkPar("R5 shift contents survive store clear");
  endtask

  task automatic testOverride();
    shiftClrN = 1'b0;
    refBits = '0;
    #3;
    for (int i = 0; i < 3; i++) doShift(1'b1);
    checkCas("R6 shift edges ignored during clear");
    shiftClrN = 1'b1;
    #3;
    doStore();
    checkPar("R6 shift stage stayed zero");
    doShift(1'b1);
    doShift(1'b0);
    doShift(1'b1);
    storeClrN = 1'b0;
    expPar = '0;
    #3;
    doStore();
    checkPar("R6 store edge ignored during clear");
    storeClrN = 1'b1;
    #3;
    doStore();
    checkPar("R6 store resumes after clear");
  endtask

  task automatic testChain();
    shiftClrN = 1'b0;
    refBits = '0;
    #3;
    shiftClrN = 1'b1;
    #3;
    for (int i = 0; i < 16; i++) doShift(patBit(i, 13));
    doStore();
    checkPar("R8 chained 16-bit load");
    check("R8 second device holds first bits", {8'd0, parB}, {8'd0, refBits[15:8]});
    checkCas("R8 chained cascade");
  endtask

  task automatic testTied();
    tieMode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      doShift(patBit(i, 9) ^ i[0]);
      check("R7 tied clocks lag one pulse", {parB, parA}, prevBits);
    end
    tieMode = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    testReset();
    testShiftStore();
    testHold();
    testIndependence();
    testOverride();
    testChain();
    testTied();
    #20;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule